// File: doc/BRIEF.md
# Serial Program Boot Loader

This block sits on the slave side of a four-wire serial link. Each transfer is a framed sequence of 24-bit words, sent most significant bit first, while the select line is held low. The first word of every frame is a command. When the command requests a boot load, the words after it carry program instructions. Each 40-bit instruction is split into two 20-bit halves, and each half travels in a separate transfer word. The block pairs the halves and writes each instruction into a 128-entry program RAM through a simple write port.

The processor core is held in soft reset from power-on until a start command arrives. A start command is a frame whose command word has the hold bit cleared and which carries no data words. Instructions beyond the last RAM entry are dropped, and a sticky flag records that this happened.

The serial clock, select and data inputs are sampled by the system clock. The serial clock therefore has to run at well below half the system clock rate.

Top module: `serial_boot_loader`

## Requirements
- R1: After reset, `core_hold` is 1, `ram_we` is 0 and `overflow` is 0.
- R2: While `cs_n` is low, one bit of `sdi` is taken on each rising edge of `sclk`. Every 24 bits form one transfer word, most significant bit first. The first word of each frame is the command.
- R3: A command with bit 6 and bit 5 both set (for example 0x000060) marks the frame as a boot frame. It restarts the write address at 0 and clears `overflow`. A command with only one of these two bits set is not a boot command.
- R4: In a boot frame, data words are taken in pairs. The first word of a pair gives the upper 20 bits of the instruction and the second word gives the lower 20 bits. Only bits 23..4 of each word are used, and bits 3..0 are ignored. The written value is {first[23:4], second[23:4]}.
- R5: Each completed instruction is written with a single `ram_we` pulse. The address starts at 0 and increases by one for each instruction.
- R6: Once 128 instructions have been written in a frame, any further completed instructions are not written and `overflow` is set. The flag stays set until the next boot command.
- R7: An upper half that has no partner when `cs_n` rises is never written.
- R8: When `cs_n` rises at the end of a frame whose command has bit 5 clear and which had no data words, `core_hold` goes to 0. The other command bits do not matter.
- R9: When `cs_n` rises at the end of a frame whose command has bit 5 set, `core_hold` goes to 1. A bit-5-clear frame that carried data words leaves `core_hold` unchanged.
- R10: Data words in a frame that is not a boot frame cause no writes.
- R11: Bits left over from an incomplete word when `cs_n` rises are discarded. The next frame starts a fresh word.
- R12: A word that completes in the same clock cycle as `cs_n` rises is still processed in full, both as a data word and as a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Frame select, active low |
| sclk | input | 1 | Serial bit clock |
| sdi | input | 1 | Serial data, MSB first |
| ram_we | output | 1 | Program RAM write strobe |
| ram_addr | output | 7 | Program RAM write address |
| ram_wdata | output | 40 | Reassembled instruction |
| core_hold | output | 1 | 1 holds the core in soft reset |
| overflow | output | 1 | Sticky: an instruction was dropped past the last entry |

## Verification
Two events can land on the same clock edge: the completion of the final transfer word and the end of the frame. The bench provokes this by raising `cs_n` on the clock right after the final serial clock edge. It does this once in a boot frame, where the closing lower half must still produce its write, and once in a command-only frame, where the start command must still release `core_hold`. Both results are judged at the ports: the bench watches for the write pulse and its data, and reads the hold level once the frame is closed.

// File: rtl/sbl_pkg.sv
package sbl_pkg;
  localparam int XFER_W   = 24;
  localparam int HALF_W   = 20;
  localparam int INSTR_W  = 2 * HALF_W;
  localparam int BOOT_BIT = 6;
  localparam int HOLD_BIT = 5;

  typedef logic [XFER_W-1:0]  xfer_t;
  typedef logic [HALF_W-1:0]  half_t;
  typedef logic [INSTR_W-1:0] instr_t;

  // Left-justified half: top HALF_W bits of a transfer word.
  function automatic half_t take_half(input xfer_t w);
    return w[XFER_W-1 -: HALF_W];
  endfunction

  function automatic instr_t join_halves(input half_t hi, input half_t lo);
    return {hi, lo};
  endfunction

  function automatic logic is_boot_cmd(input xfer_t cmd);
    return cmd[BOOT_BIT] & cmd[HOLD_BIT];
  endfunction

  function automatic logic wants_hold(input xfer_t cmd);
    return cmd[HOLD_BIT];
  endfunction
endpackage

// File: rtl/sbl_deser.sv
module sbl_deser
  import sbl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cs_n,
  input  logic  sclk,
  input  logic  sdi,
  output logic  word_valid,
  output xfer_t word,
  output logic  cs_rise
);
  localparam int CW = $clog2(XFER_W);

  logic          sclk_q;
  logic          cs_q;
  logic [CW-1:0] bit_cnt;
  xfer_t         shreg;
  logic          sclk_rise;

  assign sclk_rise = sclk & ~sclk_q & ~cs_n;
  assign cs_rise   = cs_n & ~cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q     <= 1'b0;
      cs_q       <= 1'b1;
      bit_cnt    <= '0;
      shreg      <= '0;
      word_valid <= 1'b0;
      word       <= '0;
    end else begin
      sclk_q     <= sclk;
      cs_q       <= cs_n;
      word_valid <= 1'b0;
      if (cs_n) begin
        bit_cnt <= '0;
      end else if (sclk_rise) begin
        shreg <= {shreg[XFER_W-2:0], sdi};
        if (bit_cnt == CW'(XFER_W - 1)) begin
          bit_cnt    <= '0;
          word_valid <= 1'b1;
          word       <= {shreg[XFER_W-2:0], sdi};
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  // R2: a word is only announced right after a sampled serial edge
  assert_word_follows_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> $past(sclk_rise));

  // R11: a deselected link leaves no partial bits behind
  assert_partial_dropped_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (bit_cnt == '0));
endmodule

// File: rtl/sbl_ctrl.sv
module sbl_ctrl
  import sbl_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          word_valid,
  input  xfer_t         word,
  input  logic          cs_rise,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output instr_t        ram_wdata,
  output logic          core_hold,
  output logic          overflow
);
  logic        got_cmd, cmd_hold, has_data, boot_frame, hi_pend;
  half_t       hi_half;
  logic [AW:0] wr_cnt;

  // Named internal events
  logic first_word, data_word, boot_cmd, pair_done, room, do_write, drop;
  logic got_cmd_n, cmd_hold_n, has_data_n, start_ev, hold_ev;

  assign first_word = word_valid & ~got_cmd;
  assign data_word  = word_valid & got_cmd;
  assign boot_cmd   = first_word & is_boot_cmd(word);
  assign pair_done  = data_word & boot_frame & hi_pend;
  assign room       = wr_cnt < (AW+1)'(DEPTH);
  assign do_write   = pair_done & room;
  assign drop       = pair_done & ~room;

  // Frame state as it stands after this cycle's word (same-cycle close).
  assign got_cmd_n  = got_cmd | word_valid;
  assign cmd_hold_n = first_word ? wants_hold(word) : cmd_hold;
  assign has_data_n = has_data | data_word;
  assign start_ev   = cs_rise & got_cmd_n & ~cmd_hold_n & ~has_data_n;
  assign hold_ev    = cs_rise & got_cmd_n & cmd_hold_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      got_cmd    <= 1'b0;
      cmd_hold   <= 1'b0;
      has_data   <= 1'b0;
      boot_frame <= 1'b0;
      hi_pend    <= 1'b0;
      hi_half    <= '0;
      wr_cnt     <= '0;
      ram_we     <= 1'b0;
      ram_addr   <= '0;
      ram_wdata  <= '0;
      core_hold  <= 1'b1;
      overflow   <= 1'b0;
    end else begin
      ram_we <= do_write;
      if (do_write) begin
        ram_addr  <= wr_cnt[AW-1:0];
        ram_wdata <= join_halves(hi_half, take_half(word));
        wr_cnt    <= wr_cnt + 1'b1;
      end
      if (drop) overflow <= 1'b1;
      if (first_word) begin
        got_cmd  <= 1'b1;
        cmd_hold <= wants_hold(word);
      end
      if (boot_cmd) begin
        boot_frame <= 1'b1;
        wr_cnt     <= '0;
        overflow   <= 1'b0;
        hi_pend    <= 1'b0;
      end
      if (data_word) begin
        has_data <= 1'b1;
        if (boot_frame) begin
          if (!hi_pend) hi_half <= take_half(word);
          hi_pend <= ~hi_pend;
        end
      end
      if (start_ev) core_hold <= 1'b0;
      if (hold_ev)  core_hold <= 1'b1;
      if (cs_rise) begin
        got_cmd    <= 1'b0;
        has_data   <= 1'b0;
        boot_frame <= 1'b0;
        hi_pend    <= 1'b0;
      end
    end
  end

  // R5: each write advances the counter to one past the written address
  assert_addr_steps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (wr_cnt == {1'b0, ram_addr} + 1'b1));

  // R5: a write strobe always stems from a finished transfer word
  assert_we_from_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> $past(word_valid));

  // R3: a boot command leaves the address at zero and overflow clear
  assert_boot_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    boot_cmd |=> (wr_cnt == '0) && !overflow);

  // R6: overflow only clears on a boot command
  assert_no_overflow_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !boot_cmd) |=> overflow);

  // R8: release of the core only at a frame end
  assert_release_at_close_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_hold) |-> $past(cs_rise));
endmodule

// File: rtl/serial_boot_loader.sv
module serial_boot_loader
  import sbl_pkg::*;
#(
  parameter int PROG_DEPTH = 128,
  localparam int AW = $clog2(PROG_DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               sclk,
  input  logic               sdi,
  output logic               ram_we,
  output logic [AW-1:0]      ram_addr,
  output logic [INSTR_W-1:0] ram_wdata,
  output logic               core_hold,
  output logic               overflow
);
  logic  word_valid;
  xfer_t word;
  logic  cs_rise;

  sbl_deser u_deser (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .sclk       (sclk),
    .sdi        (sdi),
    .word_valid (word_valid),
    .word       (word),
    .cs_rise    (cs_rise)
  );

  sbl_ctrl #(.DEPTH(PROG_DEPTH)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_valid (word_valid),
    .word       (word),
    .cs_rise    (cs_rise),
    .ram_we     (ram_we),
    .ram_addr   (ram_addr),
    .ram_wdata  (ram_wdata),
    .core_hold  (core_hold),
    .overflow   (overflow)
  );
endmodule

// File: tb/serial_boot_loader_test.sv
module serial_boot_loader_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b0;
  logic        sdi = 1'b0;
  logic        ram_we;
  logic [6:0]  ram_addr;
  logic [39:0] ram_wdata;
  logic        core_hold;
  logic        overflow;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  serial_boot_loader uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .core_hold(core_hold), .overflow(overflow)
  );

  // Data word k of a frame with base fb; low nibble varies too.
  function automatic logic [23:0] gen(input int k);
    logic [23:0] v;
    v = 24'(k * 24'h05A3C7 + 24'h00001F) ^ {8'(k), 16'h0};
    return v;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Write monitor (R4, R5)
  int mon_n  = 0;
  int mon_fb = 0;
  always @(negedge clk) begin
    if (rst_n && ram_we) begin
      check("R5 addr", 64'(ram_addr), 64'(mon_n));
      check("R4 data", 64'(ram_wdata),
            64'({gen(mon_fb + 2*mon_n)[23:4], gen(mon_fb + 2*mon_n + 1)[23:4]}));
      mon_n++;
    end
  end

  task automatic send_bits(input logic [23:0] w, input int nbits);
    for (int i = 23; i > 23 - nbits; i--) begin
      @(negedge clk); sclk = 1'b0; sdi = w[i];
      @(negedge clk); sclk = 1'b1;
    end
  endtask

  task automatic run_frame(input logic [23:0] cmd, input int ndata, input int fb,
                           input bit fast, input int partial);
    mon_n  = 0;
    mon_fb = fb;
    @(negedge clk); cs_n = 1'b0;
    send_bits(cmd, 24);
    for (int k = 0; k < ndata; k++) send_bits(gen(fb + k), 24);
    if (partial > 0) send_bits(24'hA5A5A5, partial);
    if (fast) begin
      @(negedge clk); sclk = 1'b0; cs_n = 1'b1;
    end else begin
      @(negedge clk); sclk = 1'b0;
      repeat (3) @(negedge clk);
      cs_n = 1'b1;
    end
    repeat (4) @(negedge clk);
  endtask

  // {cmd[24], ndata[16], writes[16], hold[1], ovf[1]}
  localparam logic [57:0] VEC [10] = '{
    {24'h000060, 16'd6,   16'd3,   1'b1, 1'b0},  // R3 R4 R5 boot
    {24'h000060, 16'd5,   16'd2,   1'b1, 1'b0},  // R7 unpaired upper
    {24'h000040, 16'd2,   16'd0,   1'b1, 1'b0},  // R3 R10 boot bit only
    {24'h000020, 16'd0,   16'd0,   1'b1, 1'b0},  // R9 hold cmd
    {24'h000000, 16'd0,   16'd0,   1'b0, 1'b0},  // R8 start
    {24'h000020, 16'd0,   16'd0,   1'b1, 1'b0},  // R9 re-hold
    {24'h000060, 16'd258, 16'd128, 1'b1, 1'b1},  // R6 overflow
    {24'h000000, 16'd1,   16'd0,   1'b1, 1'b1},  // R9 R10 R6 sticky
    {24'h000060, 16'd2,   16'd1,   1'b1, 1'b0},  // R3 clears overflow
    {24'h00009F, 16'd0,   16'd0,   1'b0, 1'b0}   // R8 other bits ignored
  };

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 core_hold", 64'(core_hold), 64'd1);
    check("R1 ram_we", 64'(ram_we), 64'd0);
    check("R1 overflow", 64'(overflow), 64'd0);

    for (int v = 0; v < 10; v++) begin
      run_frame(VEC[v][57:34], int'(VEC[v][33:18]), v * 1000, 1'b0, 0);
      check("R2 R5 R6 R7 R10 write count", 64'(mon_n), 64'(VEC[v][17:2]));
      check("R8 R9 core_hold", 64'(core_hold), 64'(VEC[v][1]));
      check("R6 overflow", 64'(overflow), 64'(VEC[v][0]));
    end

    // R11: partial word at frame end is dropped, then a fresh frame aligns
    run_frame(24'h000060, 1, 20000, 1'b0, 10);
    check("R11 R7 partial frame writes", 64'(mon_n), 64'd0);
    run_frame(24'h000060, 2, 21000, 1'b0, 0);
    check("R11 next frame writes", 64'(mon_n), 64'd1);

    // R12: final word completes on the same edge the frame closes
    run_frame(24'h000060, 2, 22000, 1'b1, 0);
    check("R12 boot write on close", 64'(mon_n), 64'd1);
    check("R12 hold after boot", 64'(core_hold), 64'd1);
    run_frame(24'h000000, 0, 23000, 1'b1, 0);
    check("R12 R8 start on close", 64'(core_hold), 64'd0);
    check("R12 no stray write", 64'(mon_n), 64'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule